// File: doc/BRIEF.md
# Wake Event Status Aggregator

This block gathers wake-up events from a set of sources and folds them into one power-management request pin. The sources are two ring-indicator lines, a keyboard data line, a mouse data line, a fan-tachometer event, a valid-infrared-frame pulse, a grouped SMI level and a parameterised bank of GPIO pins. Each source has a sticky status bit and an enable bit. Software reads and writes both through a byte-wide register port.

Asynchronous inputs pass through a two-flop synchronizer and then an edge detector. The edge detector turns each qualifying transition into a one-cycle set pulse. A status bit latches whether or not the global enable is set. The request pin only asserts when the global enable is on and some source has both its status and its enable bit set. The pin can be active high or active low, and it can be driven push-pull or open-drain.

Register map (offset: content):
- 0x0: source status, W1C. Bit 0 ring 0, bit 1 ring 1, bit 2 keyboard, bit 3 mouse, bit 4 fan, bit 5 infrared.
- 0x1: enables for the same bits.
- 0x2: SMI status at bit 3, W1C.
- 0x3: SMI enable at bit 3.
- 0x4: GPIO status, W1C, bit n for GPIO n.
- 0x5: GPIO enables.
- 0x6: GPIO falling-edge select.
- 0x7: GPIO both-edge select.
- 0x8: output control. Bit 0 global enable, bit 1 active high, bit 7 push-pull.
- 0x9: SMI routing, bit 5.
- 0xA: read-only summary, bit 0.

Top module: `wake_aggregator`

## Requirements
- R1: A falling edge on either ring-indicator input, the keyboard line or the mouse line sets its status bit. A rising fan event and a high infrared-frame pulse do the same. Each bit reads back within five clocks of the edge, whatever the global enable (0x8 bit 0).
- R2: The request pin asserts only when the global enable is set and at least one source has both its status and enable bits set. While the global enable is clear, the pin never asserts.
- R3: A status bit clears only when 1 is written to its position in its status register. Writing 0 leaves it set.
- R4: Summary bit 0 of 0x0A reads 1 while any source has both its status and enable bits set. It stays 1 until every such bit has been cleared.
- R5: A GPIO with its falling-edge select bit at 0 (the default) is set by a rising edge. With the select bit at 1 it is set by a falling edge, and a rising edge then has no effect.
- R6: A GPIO with its both-edge bit set is set by either edge.
- R7: Bit 1 of 0x08 picks active high (1) or active low (0). Bit 7 picks push-pull (1) or open-drain (0). After reset the pin is active low and open-drain.
- R8: In open-drain mode, `pme_oe` is 1 only while the pin level is low, and `pme_o` is then 0. In push-pull mode, `pme_oe` is always 1 and `pme_o` carries the level.
- R9: The grouped SMI input sets bit 3 of 0x02 only while bit 5 of 0x09 is set.
- R10: When a set pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R11: After reset, every status, enable, edge-select and control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ri_n | input | 2 | Ring-indicator inputs, active low, asynchronous |
| kbd_data | input | 1 | Keyboard data line, asynchronous |
| mouse_data | input | 1 | Mouse data line, asynchronous |
| gpio_in | input | GPIO_W | GPIO wake inputs, asynchronous |
| fan_evt | input | 1 | Fan-tach event, asynchronous, rising edge |
| ir_frame_ok | input | 1 | Synchronous one-cycle valid infrared frame pulse |
| smi_group | input | 1 | Synchronous grouped SMI level |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pme_o | output | 1 | Request pin data |
| pme_oe | output | 1 | Request pin output enable |

## Verification
The bench builds the block with GPIO_W set to 4. This makes the GPIO registers narrower than the byte port, so the zero-filled upper read bits are checked along with the per-pin edge modes. Four GPIO pins are enough to place the rising, falling and both-edge modes on separate pins in one pass. The pin state is judged as an external pull-up would see it, with the line released when `pme_oe` is low, across both polarities and both driver types.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_STS0 = 4'h0;
  localparam logic [REG_AW-1:0] A_EN0  = 4'h1;
  localparam logic [REG_AW-1:0] A_STS2 = 4'h2;
  localparam logic [REG_AW-1:0] A_EN2  = 4'h3;
  localparam logic [REG_AW-1:0] A_GSTS = 4'h4;
  localparam logic [REG_AW-1:0] A_GEN  = 4'h5;
  localparam logic [REG_AW-1:0] A_GINV = 4'h6;
  localparam logic [REG_AW-1:0] A_GBTH = 4'h7;
  localparam logic [REG_AW-1:0] A_CTRL = 4'h8;
  localparam logic [REG_AW-1:0] A_ROUT = 4'h9;
  localparam logic [REG_AW-1:0] A_SUMM = 4'hA;
  localparam int SMI_BIT   = 3;
  localparam int ROUTE_BIT = 5;

  typedef struct packed {
    logic push_pull;
    logic act_high;
    logic glob_en;
  } ctrl_t;

  function automatic logic pin_level(input logic req, input logic act_high);
    return act_high ? req : ~req;
  endfunction

  function automatic logic pin_drive_en(input logic level, input logic push_pull);
    return push_pull | ~level;
  endfunction
endpackage

// File: rtl/wake_edge.sv
module wake_edge #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] fall_sel,
  input  logic [W-1:0] both_sel,
  output logic [W-1:0] pulse
);
  logic [W-1:0] s1_q, s2_q, prv_q;
  logic [W-1:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= RST_VAL;
      s2_q  <= RST_VAL;
      prv_q <= RST_VAL;
    end else begin
      s1_q  <= din;
      s2_q  <= s1_q;
      prv_q <= s2_q;
    end
  end

  assign rise = s2_q & ~prv_q;
  assign fall = ~s2_q & prv_q;

  for (genvar i = 0; i < W; i++) begin : g_sel
    always_comb begin
      if (both_sel[i])      pulse[i] = rise[i] | fall[i];
      else if (fall_sel[i]) pulse[i] = fall[i];
      else                  pulse[i] = rise[i];
    end
  end
endmodule

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] en_v,
  output logic [W-1:0] sts_q,
  output logic         hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_v) | set_v;
  end

  assign hit = |(sts_q & en_v);
endmodule

// File: rtl/wake_pin_drv.sv
module wake_pin_drv
  import wake_pkg::*;
(
  input  logic  req,
  input  ctrl_t ctrl,
  output logic  pme_o,
  output logic  pme_oe
);
  logic level;
  assign level  = pin_level(req, ctrl.act_high);
  assign pme_oe = pin_drive_en(level, ctrl.push_pull);
  assign pme_o  = ctrl.push_pull ? level : 1'b0;
endmodule

// File: rtl/wake_aggregator.sv
module wake_aggregator
  import wake_pkg::*;
#(
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ri_n,
  input  logic              kbd_data,
  input  logic              mouse_data,
  input  logic [GPIO_W-1:0] gpio_in,
  input  logic              fan_evt,
  input  logic              ir_frame_ok,
  input  logic              smi_group,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              pme_o,
  output logic              pme_oe
);
  localparam int NFIX = 6;
  localparam int NASY = 5;
  localparam int NSRC = NFIX + 1 + GPIO_W;
  localparam int GLO  = NFIX + 1;

  logic [NFIX-1:0]   en_fix_q;
  logic              en_smi_q;
  logic [GPIO_W-1:0] en_gpio_q, gfall_q, gboth_q;
  ctrl_t             ctrl_q;
  logic              route_q;

  logic [NASY-1:0]   asy_set;
  logic [GPIO_W-1:0] gpio_set;
  logic [NSRC-1:0]   set_v, clr_v, en_v, sts_v;
  logic              hit, req;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_fix_q  <= '0;
      en_smi_q  <= 1'b0;
      en_gpio_q <= '0;
      gfall_q   <= '0;
      gboth_q   <= '0;
      ctrl_q    <= '0;
      route_q   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_EN0:  en_fix_q  <= reg_wdata[NFIX-1:0];
        A_EN2:  en_smi_q  <= reg_wdata[SMI_BIT];
        A_GEN:  en_gpio_q <= reg_wdata[GPIO_W-1:0];
        A_GINV: gfall_q   <= reg_wdata[GPIO_W-1:0];
        A_GBTH: gboth_q   <= reg_wdata[GPIO_W-1:0];
        A_CTRL: ctrl_q    <= '{push_pull: reg_wdata[7], act_high: reg_wdata[1],
                               glob_en: reg_wdata[0]};
        A_ROUT: route_q   <= reg_wdata[ROUTE_BIT];
        default: ;
      endcase
    end
  end

  // Fixed asynchronous sources: ring0, ring1, kbd, mouse fall; fan rises
  wake_edge #(.W(NASY), .RST_VAL(5'b01111)) u_asy_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      ({fan_evt, mouse_data, kbd_data, ri_n[1], ri_n[0]}),
    .fall_sel (5'b01111),
    .both_sel (5'b00000),
    .pulse    (asy_set)
  );

  wake_edge #(.W(GPIO_W), .RST_VAL('0)) u_gpio_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (gpio_in),
    .fall_sel (gfall_q),
    .both_sel (gboth_q),
    .pulse    (gpio_set)
  );

  assign set_v = {gpio_set, smi_group & route_q, ir_frame_ok, asy_set};
  assign en_v  = {en_gpio_q, en_smi_q, en_fix_q};

  always_comb begin
    clr_v = '0;
    if (reg_wr) begin
      case (reg_addr)
        A_STS0: clr_v[NFIX-1:0]      = reg_wdata[NFIX-1:0];
        A_STS2: clr_v[NFIX]          = reg_wdata[SMI_BIT];
        A_GSTS: clr_v[NSRC-1:GLO]    = reg_wdata[GPIO_W-1:0];
        default: ;
      endcase
    end
  end

  wake_status_bank #(.W(NSRC)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (set_v),
    .clr_v (clr_v),
    .en_v  (en_v),
    .sts_q (sts_v),
    .hit   (hit)
  );

  assign req = ctrl_q.glob_en & hit;

  wake_pin_drv u_pin (
    .req    (req),
    .ctrl   (ctrl_q),
    .pme_o  (pme_o),
    .pme_oe (pme_oe)
  );

  // Register reads
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STS0: reg_rdata = 8'(sts_v[NFIX-1:0]);
      A_EN0:  reg_rdata = 8'(en_fix_q);
      A_STS2: reg_rdata[SMI_BIT] = sts_v[NFIX];
      A_EN2:  reg_rdata[SMI_BIT] = en_smi_q;
      A_GSTS: reg_rdata = 8'(sts_v[NSRC-1:GLO]);
      A_GEN:  reg_rdata = 8'(en_gpio_q);
      A_GINV: reg_rdata = 8'(gfall_q);
      A_GBTH: reg_rdata = 8'(gboth_q);
      A_CTRL: reg_rdata = {ctrl_q.push_pull, 5'b0, ctrl_q.act_high, ctrl_q.glob_en};
      A_ROUT: reg_rdata[ROUTE_BIT] = route_q;
      A_SUMM: reg_rdata[0] = hit;
      default: ;
    endcase
  end
endmodule

// File: rtl/wake_aggregator_chk.sv
module wake_aggregator_chk #(
  parameter int NSRC = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] sts_v,
  input logic [NSRC-1:0] set_v,
  input logic [NSRC-1:0] clr_v,
  input logic            glob_en,
  input logic            push_pull,
  input logic            req,
  input logic            pme_o,
  input logic            pme_oe
);
  p_sts_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_v) & ~$past(clr_v) & ~sts_v) == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> (($past(set_v) & ~sts_v) == '0));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !req);

  p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_pull && pme_oe) |-> !pme_o);

  p_pp_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push_pull |-> pme_oe);
endmodule

bind wake_aggregator wake_aggregator_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sts_v     (sts_v),
  .set_v     (set_v),
  .clr_v     (clr_v),
  .glob_en   (ctrl_q.glob_en),
  .push_pull (ctrl_q.push_pull),
  .req       (req),
  .pme_o     (pme_o),
  .pme_oe    (pme_oe)
);

// File: tb/test_wake_aggregator.sv
`timescale 1ns/1ps
module test_wake_aggregator;
  localparam int GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    ri_n = 2'b11;
  logic          kbd_data = 1'b1, mouse_data = 1'b1;
  logic [GW-1:0] gpio_in = '0;
  logic          fan_evt = 1'b0, ir_frame_ok = 1'b0, smi_group = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          pme_o, pme_oe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wake_aggregator #(.GPIO_W(GW)) i_wake_aggregator (
    .clk(clk), .rst_n(rst_n), .ri_n(ri_n), .kbd_data(kbd_data),
    .mouse_data(mouse_data), .gpio_in(gpio_in), .fan_evt(fan_evt),
    .ir_frame_ok(ir_frame_ok), .smi_group(smi_group), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pme_o(pme_o), .pme_oe(pme_oe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  // external pull-up view of the pin
  function automatic logic [7:0] pin();
    return {7'b0, pme_oe ? pme_o : 1'b1};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a <= 10; a++) begin
      rd(4'(a), d);
      chk($sformatf("R11 reset reg %0d", a), d, 8'h00);
    end
    chk("R7 reset pin released", {7'b0, pme_oe}, 8'h00);
  endtask

  task automatic t_ring_gate();
    logic [7:0] d;
    wr(4'h1, 8'h01);
    @(negedge clk) ri_n[0] = 1'b0;
    settle();
    rd(4'h0, d); chk("R1 ring0 status without global enable", d, 8'h01);
    chk("R2 pin idle with global enable clear", pin(), 8'h01);
    wr(4'h8, 8'h01);
    #1 chk("R2 pin low when enabled", pin(), 8'h00);
    chk("R8 open-drain drives when low", {7'b0, pme_oe}, 8'h01);
    rd(4'hA, d); chk("R4 summary set", d, 8'h01);
    @(negedge clk) ri_n[0] = 1'b1;
    settle();
    rd(4'h0, d); chk("R1 rising ring edge ignored", d, 8'h01);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    wr(4'h0, 8'h00);
    rd(4'h0, d); chk("R3 write 0 keeps status", d, 8'h01);
    @(negedge clk) begin kbd_data = 1'b0; mouse_data = 1'b0; fan_evt = 1'b1; ri_n[1] = 1'b0; end
    settle();
    rd(4'h0, d); chk("R1 kbd mouse fan ring1 set", d, 8'h1F);
    wr(4'h1, 8'h03);
    wr(4'h0, 8'h01);
    rd(4'h0, d); chk("R3 w1c clears only bit0", d, 8'h1E);
    rd(4'hA, d); chk("R4 summary held by ring1", d, 8'h01);
    chk("R2 pin still asserted", pin(), 8'h00);
    wr(4'h0, 8'h02);
    rd(4'hA, d); chk("R4 summary clear after last enabled", d, 8'h00);
    chk("R2 pin released", pin(), 8'h01);
    wr(4'h0, 8'h1C);
    rd(4'h0, d); chk("R3 all cleared", d, 8'h00);
    @(negedge clk) begin kbd_data = 1'b1; mouse_data = 1'b1; fan_evt = 1'b0; ri_n[1] = 1'b1; end
    settle();
    rd(4'h0, d); chk("R1 inactive edges ignored", d, 8'h00);
  endtask

  task automatic t_gpio();
    logic [7:0] d;
    wr(4'h6, 8'h02);
    wr(4'h7, 8'h04);
    @(negedge clk) gpio_in = 4'b0111;
    settle();
    rd(4'h4, d); chk("R5 R6 rising: pin0 and pin2 only", d, 8'h05);
    wr(4'h4, 8'hFF);
    rd(4'h4, d); chk("R3 gpio cleared", d, 8'h00);
    @(negedge clk) gpio_in = 4'b0000;
    settle();
    rd(4'h4, d); chk("R5 R6 falling: pin1 and pin2 only", d, 8'h06);
    rd(4'h6, d); chk("R11 gpio select width", d, 8'h02);
    wr(4'h4, 8'hFF);
  endtask

  task automatic t_smi();
    logic [7:0] d;
    @(negedge clk) smi_group = 1'b1;
    settle();
    rd(4'h2, d); chk("R9 smi blocked without route", d, 8'h00);
    wr(4'h9, 8'h20);
    rd(4'h2, d); chk("R9 smi status at bit3", d, 8'h08);
    @(negedge clk) smi_group = 1'b0;
    wr(4'h2, 8'h08);
    rd(4'h2, d); chk("R3 smi cleared", d, 8'h00);
  endtask

  task automatic t_polarity();
    @(negedge clk) ri_n[0] = 1'b0;
    settle();
    wr(4'h8, 8'h03);
    #1 chk("R7 R8 open-drain active high asserted releases", {6'b0, pme_oe, pin()[0]}, 8'h01);
    wr(4'h8, 8'h83);
    #1 chk("R7 R8 push-pull active high drives 1", {6'b0, pme_oe, pme_o}, 8'h03);
    wr(4'h0, 8'h01);
    #1 chk("R8 push-pull drives inactive low", {6'b0, pme_oe, pme_o}, 8'h02);
    wr(4'h8, 8'h00);
    #1 chk("R2 global clear idle", pin(), 8'h01);
    @(negedge clk) ri_n[0] = 1'b1;
    settle();
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    @(negedge clk) begin
      ir_frame_ok = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h20; reg_wr = 1'b1;
    end
    @(negedge clk) begin ir_frame_ok = 1'b0; reg_wr = 1'b0; end
    rd(4'h0, d); chk("R10 set wins over clear", d, 8'h20);
    wr(4'h0, 8'h20);
    rd(4'h0, d); chk("R3 ir cleared", d, 8'h00);
  endtask

  initial begin
    #200_000_0;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ring_gate();
    t_w1c();
    t_gpio();
    t_smi();
    t_polarity();
    t_set_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule